// File: doc/BRIEF.md
# Banked Stream Staging Buffer

This block is the on-chip staging store that sits between a set of parallel compute lanes and the memory system. Its storage is split into one bank per lane. A stream is a block of records, described by a base row and a length in elements. Element `i` of a stream is held in bank `i mod LANES`, at row `base + i div LANES`. A producing kernel writes a stream one row per beat, and each lane stores only into its own bank. A consuming kernel later reads that stream back from the same banks, two rows per request, so each lane gets two words per cycle from its local bank.

A memory-side port moves whole streams into or out of the banks one element per beat, ahead of the kernel that needs them. Nothing is fetched on demand. Nothing is evicted: a word keeps its value until some port writes over it. Each cycle, a bank that a lane port touches belongs to the lanes. A memory-side beat aimed at that bank waits.

Top module: `stream_reg_file`

## Requirements
- R1: Stream element `i` maps to bank `i mod LANES` (8 by default), row `(base + i div LANES) mod BANK_DEPTH`. A stream moved in through the memory-side port reads back through the lane read port at exactly those positions, including a stream whose rows wrap past the last row.
- R2: After `wstr_start` with a non-zero length, each cycle with `wstr_valid` high writes row `k`. In that row, lane `j` stores `wstr_data[32j+31:32j]` as element `k*LANES+j`. Elements at or beyond the length are not written. `wstr_busy` drops after the beat that carries the last element.
- R3: A cycle with `rstr_req` high on a loaded, unfinished read stream at row pointer `r` returns data on the next cycle. Lane `j` presents element `r*LANES+j` on `rstr_data0` and element `(r+1)*LANES+j` on `rstr_data1`. Bit `j` of `rstr_vld0` and `rstr_vld1` is 1 exactly when that element is below the length. The pointer then advances by two rows.
- R4: `rstr_eos` is high once the read pointer has passed the stream length. A request made while it is high returns all-zero valid masks.
- R5: After `xfer_start`, a beat is a cycle with `xfer_valid` and `xfer_ready` both high. With `xfer_dir`=0, successive beats store `xfer_wdata` as elements 0, 1, 2, … of the stream. `xfer_busy` falls after the beat for the last element.
- R6: With `xfer_dir`=1, the word for each beat appears on `xfer_rdata` with `xfer_rvalid` high in the next cycle. `xfer_rvalid` is low in cycles that follow no such beat.
- R7: When the bank of the next memory-side element is used this cycle by the lane write or lane read port, `xfer_ready` is low and the transfer holds its position. A lane access to other banks does not hold it back.
- R8: Reading a stream does not consume it: a second read of the same stream returns the same words.
- R9: Out of reset, `wstr_busy`, `xfer_busy`, `xfer_rvalid`, `rstr_eos` and both valid masks are low.
- R10: `wstr_valid` while no write stream is active changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wstr_start | input | 1 | Load write-stream descriptor |
| wstr_base | input | AW | Write-stream base row |
| wstr_len | input | LW | Write-stream length in elements |
| wstr_valid | input | 1 | One row from all lanes this cycle |
| wstr_data | input | LANES*DW | Lane words, lane j in slice j |
| wstr_busy | output | 1 | Write stream still accepting rows |
| rstr_start | input | 1 | Load read-stream descriptor |
| rstr_base | input | AW | Read-stream base row |
| rstr_len | input | LW | Read-stream length in elements |
| rstr_req | input | 1 | Fetch next two rows |
| rstr_data0 | output | LANES*DW | First-row word per lane |
| rstr_data1 | output | LANES*DW | Second-row word per lane |
| rstr_vld0 | output | LANES | Live mask for rstr_data0 |
| rstr_vld1 | output | LANES | Live mask for rstr_data1 |
| rstr_eos | output | 1 | Read pointer past stream length |
| xfer_start | input | 1 | Load memory-side descriptor |
| xfer_dir | input | 1 | 0 = into banks, 1 = out of banks |
| xfer_base | input | AW | Memory-side base row |
| xfer_len | input | LW | Memory-side length in elements |
| xfer_valid | input | 1 | Offer one element beat |
| xfer_wdata | input | DW | Inbound element word |
| xfer_ready | output | 1 | Beat may complete this cycle |
| xfer_busy | output | 1 | Memory-side transfer in progress |
| xfer_rdata | output | DW | Outbound element word |
| xfer_rvalid | output | 1 | xfer_rdata holds a beat's word |

## Verification
The hardest case to reach from the ports is a memory-side beat colliding with a lane access in the very cycle the transfer points at that lane's bank. It needs a transfer parked on a chosen element while the lane port touches exactly one bank. The stimulus uses a one-element read stream, whose request occupies bank 0 alone. It raises that request together with a transfer beat aimed at bank 0, then repeats the request once the transfer has advanced to bank 1. This shows both the stall and the absence of one. Partial rows, in both the write and the read direction, are reached with stream lengths that are not multiples of the lane count.

// File: rtl/srf_pkg.sv
`timescale 1ns/1ps
package srf_pkg;

  function automatic int bank_of(int elem, int lanes);
    return elem % lanes;
  endfunction

  function automatic int row_of(int elem, int lanes);
    return elem / lanes;
  endfunction

  function automatic logic elem_live(int row, int lane, int lanes, int len);
    return (row * lanes + lane) < len;
  endfunction

  function automatic logic past_end(int row, int lanes, int len);
    return (row * lanes) >= len;
  endfunction

endpackage

// File: rtl/srf_bank.sv
`timescale 1ns/1ps
module srf_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re0,
  input  logic [AW-1:0] raddr0,
  input  logic          re1,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rdata0,
  output logic [DW-1:0] rdata1
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re0) rdata0 <= mem[raddr0];
    if (re1) rdata1 <= mem[raddr1];
  end
endmodule

// File: rtl/srf_wstream.sv
`timescale 1ns/1ps
module srf_wstream #(
  parameter int LANES = 8,
  parameter int AW    = 8,
  parameter int LW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base,
  input  logic [LW-1:0]    len,
  input  logic             valid,
  output logic             busy,
  output logic [LANES-1:0] we_mask,
  output logic [AW-1:0]    row_addr
);
  logic          active_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] row_q;
  logic          beat;

  assign beat     = valid & active_q;
  assign busy     = active_q;
  assign row_addr = base_q + AW'(row_q);

  for (genvar j = 0; j < LANES; j++) begin : g_mask
    assign we_mask[j] = beat & srf_pkg::elem_live(int'(row_q), j, LANES, int'(len_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      len_q    <= '0;
      row_q    <= '0;
    end else if (start) begin
      active_q <= (len != '0);
      base_q   <= base;
      len_q    <= len;
      row_q    <= '0;
    end else if (beat) begin
      row_q <= row_q + 1'b1;
      if (srf_pkg::past_end(int'(row_q) + 1, LANES, int'(len_q))) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/srf_rstream.sv
`timescale 1ns/1ps
module srf_rstream #(
  parameter int LANES = 8,
  parameter int AW    = 8,
  parameter int LW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base,
  input  logic [LW-1:0]    len,
  input  logic             req,
  output logic [LANES-1:0] mask0,
  output logic [LANES-1:0] mask1,
  output logic [AW-1:0]    addr0,
  output logic [AW-1:0]    addr1,
  output logic [LANES-1:0] vld0,
  output logic [LANES-1:0] vld1,
  output logic             eos
);
  logic          loaded_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] row_q;
  logic          issue;

  assign eos   = loaded_q & srf_pkg::past_end(int'(row_q), LANES, int'(len_q));
  assign issue = req & loaded_q & ~eos;
  assign addr0 = base_q + AW'(row_q);
  assign addr1 = addr0 + 1'b1;

  for (genvar j = 0; j < LANES; j++) begin : g_mask
    assign mask0[j] = issue & srf_pkg::elem_live(int'(row_q), j, LANES, int'(len_q));
    assign mask1[j] = issue & srf_pkg::elem_live(int'(row_q) + 1, j, LANES, int'(len_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      base_q   <= '0;
      len_q    <= '0;
      row_q    <= '0;
      vld0     <= '0;
      vld1     <= '0;
    end else begin
      vld0 <= mask0;
      vld1 <= mask1;
      if (start) begin
        loaded_q <= 1'b1;
        base_q   <= base;
        len_q    <= len;
        row_q    <= '0;
      end else if (issue) begin
        row_q <= row_q + LW'(2);
      end
    end
  end
endmodule

// File: rtl/srf_xfer.sv
`timescale 1ns/1ps
module srf_xfer #(
  parameter int LANES = 8,
  parameter int AW    = 8,
  parameter int LW    = 12,
  parameter int BW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic [AW-1:0]    base,
  input  logic [LW-1:0]    len,
  input  logic             valid,
  input  logic [LANES-1:0] lane_busy,
  output logic             busy,
  output logic             ready,
  output logic             we,
  output logic             re,
  output logic [BW-1:0]    bank,
  output logic [AW-1:0]    row_addr
);
  logic          active_q;
  logic          dir_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] cnt_q;
  logic          beat;

  assign bank     = BW'(srf_pkg::bank_of(int'(cnt_q), LANES));
  assign row_addr = base_q + AW'(srf_pkg::row_of(int'(cnt_q), LANES));
  assign busy     = active_q;
  assign ready    = active_q & ~lane_busy[bank];
  assign beat     = ready & valid;
  assign we       = beat & ~dir_q;
  assign re       = beat & dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_q    <= 1'b0;
      base_q   <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= (len != '0);
      dir_q    <= dir;
      base_q   <= base;
      len_q    <= len;
      cnt_q    <= '0;
    end else if (beat) begin
      cnt_q <= cnt_q + 1'b1;
      if (int'(cnt_q) + 1 >= int'(len_q)) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/stream_reg_file.sv
`timescale 1ns/1ps
module stream_reg_file #(
  parameter  int LANES      = 8,
  parameter  int DW         = 32,
  parameter  int BANK_DEPTH = 256,
  localparam int AW         = $clog2(BANK_DEPTH),
  localparam int LW         = $clog2(LANES * BANK_DEPTH) + 1,
  localparam int BW         = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wstr_start,
  input  logic [AW-1:0]       wstr_base,
  input  logic [LW-1:0]       wstr_len,
  input  logic                wstr_valid,
  input  logic [LANES*DW-1:0] wstr_data,
  output logic                wstr_busy,
  input  logic                rstr_start,
  input  logic [AW-1:0]       rstr_base,
  input  logic [LW-1:0]       rstr_len,
  input  logic                rstr_req,
  output logic [LANES*DW-1:0] rstr_data0,
  output logic [LANES*DW-1:0] rstr_data1,
  output logic [LANES-1:0]    rstr_vld0,
  output logic [LANES-1:0]    rstr_vld1,
  output logic                rstr_eos,
  input  logic                xfer_start,
  input  logic                xfer_dir,
  input  logic [AW-1:0]       xfer_base,
  input  logic [LW-1:0]       xfer_len,
  input  logic                xfer_valid,
  input  logic [DW-1:0]       xfer_wdata,
  output logic                xfer_ready,
  output logic                xfer_busy,
  output logic [DW-1:0]       xfer_rdata,
  output logic                xfer_rvalid
);
  logic [LANES-1:0] w_mask;
  logic [AW-1:0]    w_row;
  logic [LANES-1:0] r_mask0, r_mask1;
  logic [AW-1:0]    r_addr0, r_addr1;
  logic [LANES-1:0] lane_busy;
  logic [LANES-1:0] xfer_hit;
  logic             x_we, x_re;
  logic [BW-1:0]    x_bank;
  logic [AW-1:0]    x_row;
  logic [BW-1:0]    xrd_bank_q;
  logic             xrd_vld_q;
  logic [DW-1:0]    bank_rd0 [LANES];
  logic [DW-1:0]    bank_rd1 [LANES];

  srf_wstream #(.LANES(LANES), .AW(AW), .LW(LW)) u_wstr (
    .clk(clk), .rst_n(rst_n), .start(wstr_start), .base(wstr_base),
    .len(wstr_len), .valid(wstr_valid), .busy(wstr_busy),
    .we_mask(w_mask), .row_addr(w_row)
  );

  srf_rstream #(.LANES(LANES), .AW(AW), .LW(LW)) u_rstr (
    .clk(clk), .rst_n(rst_n), .start(rstr_start), .base(rstr_base),
    .len(rstr_len), .req(rstr_req), .mask0(r_mask0), .mask1(r_mask1),
    .addr0(r_addr0), .addr1(r_addr1), .vld0(rstr_vld0), .vld1(rstr_vld1),
    .eos(rstr_eos)
  );

  assign lane_busy = w_mask | r_mask0 | r_mask1;

  srf_xfer #(.LANES(LANES), .AW(AW), .LW(LW), .BW(BW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .dir(xfer_dir),
    .base(xfer_base), .len(xfer_len), .valid(xfer_valid),
    .lane_busy(lane_busy), .busy(xfer_busy), .ready(xfer_ready),
    .we(x_we), .re(x_re), .bank(x_bank), .row_addr(x_row)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic          bwe, bre0;
    logic [AW-1:0] bwaddr, braddr0;
    logic [DW-1:0] bwdata;

    assign xfer_hit[b] = (x_we | x_re) & (x_bank == BW'(b));
    assign bwe     = w_mask[b] | (x_we & xfer_hit[b]);
    assign bwaddr  = w_mask[b] ? w_row : x_row;
    assign bwdata  = w_mask[b] ? wstr_data[b*DW +: DW] : xfer_wdata;
    assign bre0    = r_mask0[b] | (x_re & xfer_hit[b]);
    assign braddr0 = r_mask0[b] ? r_addr0 : x_row;

    srf_bank #(.DW(DW), .DEPTH(BANK_DEPTH), .AW(AW)) u_bank (
      .clk(clk), .we(bwe), .waddr(bwaddr), .wdata(bwdata),
      .re0(bre0), .raddr0(braddr0), .re1(r_mask1[b]), .raddr1(r_addr1),
      .rdata0(bank_rd0[b]), .rdata1(bank_rd1[b])
    );

    assign rstr_data0[b*DW +: DW] = bank_rd0[b];
    assign rstr_data1[b*DW +: DW] = bank_rd1[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xrd_bank_q <= '0;
      xrd_vld_q  <= 1'b0;
    end else begin
      xrd_vld_q <= x_re;
      if (x_re) xrd_bank_q <= x_bank;
    end
  end

  assign xfer_rvalid = xrd_vld_q;
  assign xfer_rdata  = bank_rd0[xrd_bank_q];
endmodule

// File: rtl/srf_checker.sv
`timescale 1ns/1ps
module srf_checker #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] lane_busy,
  input logic [LANES-1:0] xfer_hit,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic             xfer_dir,
  input logic             xfer_busy,
  input logic             xfer_rvalid,
  input logic             rstr_req,
  input logic             rstr_eos,
  input logic [LANES-1:0] rstr_vld0,
  input logic [LANES-1:0] rstr_vld1,
  input logic             wstr_busy,
  input logic             wstr_valid,
  input logic             wstr_start
);
  // R7: a memory-side access never lands on a bank the lanes hold
  a_r7_lane_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_hit & lane_busy) == '0);

  // R6: an outbound beat yields a data word one cycle later
  a_r6_out_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && xfer_dir && xfer_busy) |=> xfer_rvalid);

  // R4: requests past the end return nothing
  a_r4_past_end_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rstr_req && rstr_eos) |=> (rstr_vld0 == '0 && rstr_vld1 == '0));

  // R3: the second row is live only when the first row is full
  a_r3_prefix_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (rstr_vld1 != '0) |-> (&rstr_vld0));

  // R2: the write stream closes only on a beat or a reload
  a_r2_close_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wstr_busy) |-> $past(wstr_valid || wstr_start));
endmodule

bind stream_reg_file srf_checker #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lane_busy(lane_busy), .xfer_hit(xfer_hit),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_dir(xfer_dir),
  .xfer_busy(xfer_busy), .xfer_rvalid(xfer_rvalid), .rstr_req(rstr_req),
  .rstr_eos(rstr_eos), .rstr_vld0(rstr_vld0), .rstr_vld1(rstr_vld1),
  .wstr_busy(wstr_busy), .wstr_valid(wstr_valid), .wstr_start(wstr_start)
);

// File: tb/stream_reg_file_tb_top.sv
`timescale 1ns/1ps
module stream_reg_file_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         wstr_start = 0, wstr_valid = 0;
  logic [7:0]   wstr_base = 0;
  logic [11:0]  wstr_len = 0;
  logic [255:0] wstr_data = '0;
  logic         wstr_busy;
  logic         rstr_start = 0, rstr_req = 0;
  logic [7:0]   rstr_base = 0;
  logic [11:0]  rstr_len = 0;
  logic [255:0] rstr_data0, rstr_data1;
  logic [7:0]   rstr_vld0, rstr_vld1;
  logic         rstr_eos;
  logic         xfer_start = 0, xfer_dir = 0, xfer_valid = 0;
  logic [7:0]   xfer_base = 0;
  logic [11:0]  xfer_len = 0;
  logic [31:0]  xfer_wdata = 0;
  logic         xfer_ready, xfer_busy, xfer_rvalid;
  logic [31:0]  xfer_rdata;

  stream_reg_file dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;

  // base(8) len(12) seed(8)
  localparam logic [27:0] VECS [6] = '{
    {8'd0,   12'd16, 8'd1},
    {8'd10,  12'd20, 8'd2},
    {8'd40,  12'd7,  8'd3},
    {8'd100, 12'd33, 8'd4},
    {8'd254, 12'd24, 8'd5},
    {8'd150, 12'd40, 8'd6}
  };

  function automatic logic [31:0] val(logic [7:0] seed, int idx);
    return {seed, 8'h5A, 16'(idx)};
  endfunction

  function automatic logic [31:0] wsv(int row, int lane);
    return {8'hC3, 8'(row), 8'(lane), 8'h3C};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xin(logic [7:0] base, int len, logic [7:0] seed);
    @(negedge clk);
    xfer_start = 1; xfer_dir = 0; xfer_base = base; xfer_len = 12'(len);
    @(negedge clk);
    xfer_start = 0;
    for (int i = 0; i < len; i++) begin
      xfer_valid = 1; xfer_wdata = val(seed, i);
      @(negedge clk);
    end
    xfer_valid = 0;
  endtask

  task automatic xout_start(logic [7:0] base, int len);
    @(negedge clk);
    xfer_start = 1; xfer_dir = 1; xfer_base = base; xfer_len = 12'(len);
    @(negedge clk);
    xfer_start = 0;
  endtask

  task automatic xout_word(output logic [31:0] d);
    xfer_valid = 1;
    @(negedge clk);
    xfer_valid = 0;
    check("R6 rvalid after beat", 64'(xfer_rvalid), 64'd1);
    d = xfer_rdata;
    @(negedge clk);
  endtask

  task automatic rd_back(logic [7:0] base, int len, logic [7:0] seed, string tag);
    int nreq;
    @(negedge clk);
    rstr_start = 1; rstr_base = base; rstr_len = 12'(len);
    @(negedge clk);
    rstr_start = 0;
    nreq = (len + 15) / 16;
    for (int k = 0; k < nreq; k++) begin
      logic [7:0] e0, e1;
      rstr_req = 1;
      @(negedge clk);
      rstr_req = 0;
      for (int j = 0; j < 8; j++) begin
        e0[j] = (k * 16 + j) < len;
        e1[j] = (k * 16 + 8 + j) < len;
      end
      check({"R3 vld0 ", tag}, 64'(rstr_vld0), 64'(e0));
      check({"R3 vld1 ", tag}, 64'(rstr_vld1), 64'(e1));
      for (int j = 0; j < 8; j++) begin
        if (e0[j]) check({"R1 data0 ", tag}, 64'(rstr_data0[j*32 +: 32]), 64'(val(seed, k*16+j)));
        if (e1[j]) check({"R1 data1 ", tag}, 64'(rstr_data1[j*32 +: 32]), 64'(val(seed, k*16+8+j)));
      end
    end
    check({"R4 eos at end ", tag}, 64'(rstr_eos), 64'd1);
    rstr_req = 1;
    @(negedge clk);
    rstr_req = 0;
    check({"R4 past end vld ", tag}, 64'({rstr_vld1, rstr_vld0}), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 wstr_busy", 64'(wstr_busy), 0);
    check("R9 xfer_busy", 64'(xfer_busy), 0);
    check("R9 rvalid", 64'(xfer_rvalid), 0);
    check("R9 eos", 64'(rstr_eos), 0);
    check("R9 vld", 64'({rstr_vld1, rstr_vld0}), 0);
    rst_n = 1;
    @(negedge clk);

    // Table: move in, then read back twice (R1, R3, R4, R5, R8)
    for (int v = 0; v < 6; v++) begin
      logic [7:0] b, s;
      int l;
      b = VECS[v][27:20]; l = int'(VECS[v][19:8]); s = VECS[v][7:0];
      xin(b, l, s);
      check("R5 busy after last beat", 64'(xfer_busy), 0);
      rd_back(b, l, s, "first");
      rd_back(b, l, s, "R8 second");
    end

    // R2 and R10: partial write stream over prefilled rows
    xin(8'd60, 16, 8'd9);
    @(negedge clk);
    wstr_start = 1; wstr_base = 8'd60; wstr_len = 12'd13;
    @(negedge clk);
    wstr_start = 0;
    check("R2 busy after start", 64'(wstr_busy), 1);
    for (int r = 0; r < 2; r++) begin
      wstr_valid = 1;
      for (int j = 0; j < 8; j++) wstr_data[j*32 +: 32] = wsv(r, j);
      @(negedge clk);
    end
    wstr_valid = 0;
    check("R2 busy after last row", 64'(wstr_busy), 0);
    wstr_valid = 1;
    for (int j = 0; j < 8; j++) wstr_data[j*32 +: 32] = 32'hDEAD0000 + 32'(j);
    @(negedge clk);
    wstr_valid = 0;
    xout_start(8'd60, 16);
    for (int i = 0; i < 16; i++) begin
      xout_word(d);
      if (i < 13) check("R2 R10 lane-written word", 64'(d), 64'(wsv(i / 8, i % 8)));
      else        check("R2 tail untouched", 64'(d), 64'(val(8'd9, i)));
    end
    check("R6 rvalid idle", 64'(xfer_rvalid), 0);

    // R7: lane read on bank 0 stalls a beat aimed at bank 0, not bank 1
    @(negedge clk);
    xfer_start = 1; xfer_dir = 0; xfer_base = 8'd200; xfer_len = 12'd2;
    rstr_start = 1; rstr_base = 8'd0; rstr_len = 12'd1;
    @(negedge clk);
    xfer_start = 0; rstr_start = 0;
    rstr_req = 1; xfer_valid = 1; xfer_wdata = val(8'd7, 0);
    #1 check("R7 stall on shared bank", 64'(xfer_ready), 0);
    @(negedge clk);
    rstr_req = 0;
    #1 check("R7 ready once bank free", 64'(xfer_ready), 1);
    check("R4 eos after single element", 64'(rstr_eos), 1);
    @(negedge clk);
    xfer_valid = 0;
    rstr_start = 1;
    @(negedge clk);
    rstr_start = 0;
    rstr_req = 1; xfer_valid = 1; xfer_wdata = val(8'd7, 1);
    #1 check("R7 no stall on other bank", 64'(xfer_ready), 1);
    @(negedge clk);
    rstr_req = 0; xfer_valid = 0;
    check("R5 transfer done", 64'(xfer_busy), 0);
    xout_start(8'd200, 2);
    for (int i = 0; i < 2; i++) begin
      xout_word(d);
      check("R5 R7 stalled transfer data", 64'(d), 64'(val(8'd7, i)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule